// File: doc/BRIEF.md
# Supply Lockout Write Inhibit Controller

This block decides, cycle by cycle, whether a nonvolatile store may begin a new program or erase operation. An external comparator gives a raw flag that is high while the supply is above its threshold. The block passes that flag through a synchronizer and a glitch filter. It then runs an asymmetric timer. When the supply becomes good, writes stay inhibited for a long hold-off. When the supply fails, writes are locked out after a short, bounded delay.

The block has two outputs. The write-permit flag gates the start of every write, erase, write-all and erase-all operation. Reads never consult it, so reading stays possible at all times. The clear flag holds the store's write-enable latch in its disabled state while the block is locked. Because of this, the store leaves power-up with writes disabled. An operation that is already running when the supply falls is not stopped; only new starts are blocked. All timing constants are parameters counted in clock cycles: `GLITCH_CYC` (G), `PWRUP_CYC` (P) and `LOCK_CYC` (L).

Top module: `supply_lockout_ctrl`

## Requirements
- R1: While reset is asserted and directly after it is released, `write_permit` is 0 and `wen_clear` is 1.
- R2: When `supply_raw` is sampled high on consecutive rising edges starting from the locked state, `write_permit` goes to 1 on the (G+P+3)th of those edges and not earlier, counting the first edge that samples it high as edge 1.
- R3: In that same sequence, `wen_clear` drops to 0 on edge G+3. Between that edge and the edge where `write_permit` rises, both outputs are 0.
- R4: If the supply falls for at least G sampled cycles during the hold-off, the block returns to the locked state (`wen_clear`=1). The whole hold-off then restarts, so the next rise again needs G+P+3 edges.
- R5: A run of fewer than G consecutive samples at the opposite level on `supply_raw`, of either polarity, leaves both outputs unchanged.
- R6: When `supply_raw` is sampled low on consecutive edges starting from the permitted state, `write_permit` drops to 0 and `wen_clear` rises to 1 on edge G+L+3.
- R7: If the supply is qualified low for no more than L cycles and then returns high, the lockout is abandoned. `write_permit` stays 1 and `wen_clear` stays 0 throughout, and no new hold-off is started.
- R8: `write_permit` and `wen_clear` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_raw | input | 1 | Unsynchronized supply-above-threshold flag from the comparator |
| write_permit | output | 1 | 1 allows the start of a new write or erase operation |
| wen_clear | output | 1 | 1 holds the write-enable latch cleared |

## Verification
Two functions can fall in the same cycle: rejecting a short excursion, and the decision in the lockout-delay window. A dip that gets past the filter but returns before L cycles must leave the permit untouched. A dip of G samples or more that stays low must turn into a lockout at exactly G+L+3 edges.

The bench drives a dip of exactly G samples from the permitted state and checks both outputs on every cycle of the window. It also times a sustained fall edge by edge. Random settle levels with sub-G glitches of both polarities are checked against levels that bench functions compute from the requirements.

// File: rtl/sl_pkg.sv
package sl_pkg;
  typedef enum logic [1:0] {
    LK_OFF  = 2'd0,
    LK_HOLD = 2'd1,
    LK_ON   = 2'd2,
    LK_FALL = 2'd3
  } lk_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/sl_glitch_filter.sv
module sl_glitch_filter #(
  parameter int unsigned GLITCH_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic qual
);
  localparam int unsigned FW = sl_pkg::cnt_width(GLITCH_CYC);
  localparam logic [FW-1:0] LAST = FW'(GLITCH_CYC - 1);

  logic [FW-1:0] run_cnt;
  logic          qual_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_r  <= 1'b0;
      run_cnt <= '0;
    end else if (din != qual_r) begin
      if (run_cnt == LAST) begin
        qual_r  <= din;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end else begin
      run_cnt <= '0;
    end
  end

  assign qual = qual_r;
endmodule

// File: rtl/sl_lock_fsm.sv
module sl_lock_fsm
  import sl_pkg::*;
#(
  parameter int unsigned PWRUP_CYC = 50_000_000,
  parameter int unsigned LOCK_CYC  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good,
  output logic permit,
  output logic clr
);
  localparam int unsigned MAXC = (PWRUP_CYC > LOCK_CYC) ? PWRUP_CYC : LOCK_CYC;
  localparam int unsigned CW   = cnt_width(MAXC);
  localparam logic [CW-1:0] P_LAST = CW'(PWRUP_CYC - 1);
  localparam logic [CW-1:0] L_LAST = CW'((LOCK_CYC == 0) ? 0 : LOCK_CYC - 1);

  lk_state_e     st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    unique case (st)
      LK_OFF: begin
        if (good) begin
          st_nx  = LK_HOLD;
          cnt_nx = '0;
        end
      end
      LK_HOLD: begin
        if (!good) begin
          st_nx  = LK_OFF;
          cnt_nx = '0;
        end else if (cnt == P_LAST) begin
          st_nx  = LK_ON;
          cnt_nx = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      LK_ON: begin
        if (!good) begin
          st_nx  = (LOCK_CYC == 0) ? LK_OFF : LK_FALL;
          cnt_nx = '0;
        end
      end
      LK_FALL: begin
        if (good) begin
          st_nx  = LK_ON;
          cnt_nx = '0;
        end else if (cnt == L_LAST) begin
          st_nx  = LK_OFF;
          cnt_nx = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      default: begin
        st_nx  = LK_OFF;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= LK_OFF;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  assign permit = (st == LK_ON) || (st == LK_FALL);
  assign clr    = (st == LK_OFF);
endmodule

// File: rtl/supply_lockout_ctrl.sv
module supply_lockout_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GLITCH_CYC  = 8,
  parameter int unsigned PWRUP_CYC   = 50_000_000,
  parameter int unsigned LOCK_CYC    = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_raw,
  output logic write_permit,
  output logic wen_clear
);
  logic s_sync;
  logic q_good;

  sl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (supply_raw),
    .d_sync  (s_sync)
  );

  sl_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (s_sync),
    .qual  (q_good)
  );

  sl_lock_fsm #(.PWRUP_CYC(PWRUP_CYC), .LOCK_CYC(LOCK_CYC)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .good   (q_good),
    .permit (write_permit),
    .clr    (wen_clear)
  );
endmodule

// File: rtl/supply_lockout_ctrl_chk.sv
module supply_lockout_ctrl_chk #(
  parameter int unsigned LOCK_CYC = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic s_sync,
  input logic q_good,
  input logic write_permit,
  input logic wen_clear
);
  localparam int unsigned LW = $clog2(LOCK_CYC + 2) + 1;
  localparam logic [LW-1:0] SAT = LW'(LOCK_CYC + 1);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_cnt <= '0;
    else if (q_good)       low_cnt <= '0;
    else if (low_cnt < SAT) low_cnt <= low_cnt + 1'b1;
  end

  // R5
  filt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_good) |-> $past(s_sync != q_good));

  // R6
  lockout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt == SAT) |-> (!write_permit && wen_clear));

  // R2
  permit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_permit) |-> ($past(q_good) && $past(!wen_clear)));

  // R3
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wen_clear) |-> !write_permit);

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(write_permit && wen_clear));
endmodule

bind supply_lockout_ctrl supply_lockout_ctrl_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .s_sync       (s_sync),
  .q_good       (q_good),
  .write_permit (write_permit),
  .wen_clear    (wen_clear)
);

// File: tb/supply_lockout_ctrl_bench.sv
module supply_lockout_ctrl_bench;
  localparam int unsigned G = 4;
  localparam int unsigned P = 40;
  localparam int unsigned L = 8;
  localparam int unsigned RISE_LAT = G + P + 3;
  localparam int unsigned FALL_LAT = G + L + 3;
  localparam int unsigned SETTLE   = G + P + L + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_raw = 1'b0;
  logic write_permit, wen_clear;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic hp [0:255];
  logic hc [0:255];

  always #2 clk = ~clk;

  supply_lockout_ctrl #(
    .SYNC_STAGES(2), .GLITCH_CYC(G), .PWRUP_CYC(P), .LOCK_CYC(L)
  ) u_supply_lockout_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_raw(supply_raw),
    .write_permit(write_permit), .wen_clear(wen_clear)
  );

  function automatic logic exp_permit(input logic lvl);
    return lvl;
  endfunction

  function automatic logic exp_clear(input logic lvl);
    return !lvl;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Steps n edges, recording outputs after each edge at the falling edge.
  task automatic watch(input int n);
    for (int e = 1; e <= n; e++) begin
      @(posedge clk);
      @(negedge clk);
      hp[e] = write_permit;
      hc[e] = wen_clear;
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    @(negedge clk);
    supply_raw = lvl;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  // R8 exclusivity monitor
  always @(negedge clk) begin
    if (rst_n) chk(write_permit && wen_clear, 1'b0, "R8", "both outputs high");
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(write_permit, 1'b0, "R1", "permit in reset");
    chk(wen_clear, 1'b1, "R1", "clear in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(write_permit, 1'b0, "R1", "permit after reset");
    chk(wen_clear, 1'b1, "R1", "clear after reset");

    // R2, R3: rise latency
    supply_raw = 1'b1;
    watch(RISE_LAT + 2);
    chk(hc[G+2], 1'b1, "R3", "clear before edge G+3");
    chk(hc[G+3], 1'b0, "R3", "clear at edge G+3");
    chk(hp[G+3], 1'b0, "R3", "permit at edge G+3");
    chk(hp[RISE_LAT-1], 1'b0, "R2", "permit one edge early");
    chk(hc[RISE_LAT-1], 1'b0, "R3", "clear during hold-off");
    chk(hp[RISE_LAT], 1'b1, "R2", "permit at rise latency");
    chk(hp[RISE_LAT+2], 1'b1, "R2", "permit stays");

    // R7: qualified dip of exactly G samples, abandoned lockout
    supply_raw = 1'b0;
    watch(G);
    supply_raw = 1'b1;
    watch(3 * G + L);
    for (int e = 1; e <= 3 * G + L; e++) begin
      chk(hp[e], 1'b1, "R7", "permit in aborted lockout");
      chk(hc[e], 1'b0, "R7", "clear in aborted lockout");
    end

    // R6: fall latency
    supply_raw = 1'b0;
    watch(FALL_LAT + 2);
    chk(hp[FALL_LAT-1], 1'b1, "R6", "permit one edge before lockout");
    chk(hc[FALL_LAT-1], 1'b0, "R6", "clear one edge before lockout");
    chk(hp[FALL_LAT], 1'b0, "R6", "permit at lockout edge");
    chk(hc[FALL_LAT], 1'b1, "R6", "clear at lockout edge");

    // R4: drop during hold-off restarts the hold-off
    supply_raw = 1'b1;
    watch(G + 15);
    chk(hc[G+15], 1'b0, "R4", "in hold-off");
    supply_raw = 1'b0;
    watch(G + 4);
    chk(wen_clear, 1'b1, "R4", "relocked after drop");
    chk(write_permit, 1'b0, "R4", "permit after drop");
    supply_raw = 1'b1;
    watch(RISE_LAT + 1);
    chk(hp[RISE_LAT-1], 1'b0, "R4", "full hold-off restarted");
    chk(hp[RISE_LAT], 1'b1, "R4", "permit after restarted hold-off");

    // R5 directed: G-1 sample glitch in each settled state
    supply_raw = 1'b0;
    watch(SETTLE);
    hold(1'b1, G - 1);
    supply_raw = 1'b0;
    watch(G + P);
    chk(write_permit, 1'b0, "R5", "short high glitch ignored");
    chk(wen_clear, 1'b1, "R5", "short high glitch ignored");

    // R5, R2, R6: random settle levels mixed with short glitches
    void'($urandom(32'h5EED_0042));
    for (int it = 0; it < 60; it++) begin
      logic lvl;
      int glen;
      lvl = 1'($urandom % 2);
      supply_raw = lvl;
      watch(SETTLE);
      chk(write_permit, exp_permit(lvl), lvl ? "R2" : "R6", "settled permit");
      chk(wen_clear, exp_clear(lvl), lvl ? "R3" : "R1", "settled clear");
      for (int g = 0; g < 3; g++) begin
        glen = 1 + int'($urandom % (G - 1));
        hold(!lvl, glen);
        supply_raw = lvl;
        watch(2 + int'($urandom % 4));
      end
      watch(G + L + 4);
      chk(write_permit, exp_permit(lvl), "R5", "permit after glitches");
      chk(wen_clear, exp_clear(lvl), "R5", "clear after glitches");
    end

    done = 1'b1;
    summary();
  end
endmodule